// File: doc/BRIEF.md
# Keypad Matrix Scanner with Press/Release Wake-Up

This block reads a 5-row by 3-column key matrix. Between scans it parks every column line low and watches the row lines. A scan starts on a key-down event (some row pulled low) or on a key-release event (every row high), depending on which detection is armed. Each scan visits the columns one at a time. For each column it first drives every column line high with push-pull drivers, to charge the line capacitance to a known level. It then switches the drivers to open-drain and pulls only the column under test low. After a settle wait it samples the active-low rows.

The keys found on all three columns are merged into a 12-bit button word, one bit per key. When the scan ends, the columns go low again and the word is latched with a one-cycle valid pulse. Exactly one detection mode is then re-armed, chosen from the word held before that scan. A hold input forces the reported word to zero and leaves the latched word untouched.

Top module: `keymatrix_scanner`

## Requirements
- R1: Between scans `col_o` is 000 and `col_pp_o` is 0 (open-drain). No scan starts until the armed event occurs.
- R2: A scan starts when press detection is armed and a synchronized row reads 0, or when release detection is armed and all synchronized rows read 1. Rows pass through a 2-flop synchronizer. Both arm outputs read 0 for the whole scan.
- R3: Each column step opens with a precharge phase of exactly SETTLE (default 256) cycles. In this phase `col_o` is 111 and `col_pp_o` is 1.
- R4: After precharge, `col_pp_o` is 0 for exactly SETTLE cycles while `col_o` holds only the scanned column's bit at 0. Columns are visited in the order 0, 1, 2, so `col_o` reads 110, then 101, then 011. Rows are sampled on the last cycle of this window.
- R5: Key map, with rows 0 to 4 and entries for columns 0/1/2:
  - row 0: left / back / vol_up
  - row 1: up / menu / vol_down
  - row 2: down / none / prev
  - row 3: right / none / play
  - row 4: select / none / next
  Bit positions in `btn_o`: left 0, right 1, up 2, down 3, select 4, back 5, menu 6, vol_up 7, vol_down 8, prev 9, play 10, next 11. Several keys found in one scan are ORed into the word, and a none position sets no bit.
- R6: After the last column, the columns return to 000 and the new word appears on `btn_o`. `btn_valid_o` is 1 for exactly that one cycle.
- R7: After each scan exactly one arm output is 1. `arm_release_o` is 1 when the word latched before this scan was non-zero. Otherwise `arm_press_o` is 1.
- R8: After reset `btn_o` is 0 and both arm outputs are 1. This forces a first scan at once, which yields word 0.
- R9: While `hold_i` is 1, `btn_o` reads 0. Releasing hold shows the latched word again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| row_n_i | input | 5 | Row lines, active low |
| hold_i | input | 1 | Hold switch; masks the reported buttons |
| col_o | output | 3 | Column data |
| col_pp_o | output | 1 | 1 = columns driven push-pull, 0 = open-drain |
| arm_press_o | output | 1 | Key-down detection armed |
| arm_release_o | output | 1 | Key-release detection armed |
| btn_o | output | 12 | Button word, masked by hold |
| btn_valid_o | output | 1 | One-cycle pulse with each new word |

## Verification
The bench presses each of the 15 matrix positions alone, then several multi-key sets: one column, one row, spread across columns, and every key. It compares each scan result with a word it computes from its own key table, and checks the arm outputs after every scan against the press/release rule.

Some faults are caught by particular checks:
- A swapped map entry or wrong bit position fails the single-key sweep.
- A design that re-arms on the new word instead of the previous one shows the wrong arm after the first scan of a press.
- Positions that map to none must keep yielding 0 while the block rescans over and over.

The phase lengths and the strobe pattern are measured cycle by cycle, so an off-by-one timer or a column order mistake shows up directly. Hold is applied while keys are down, and the bench checks that releasing it brings the same word back.

// File: rtl/kms_pkg.sv
// Shared types and the key map for the keypad matrix scanner.
// Assumes a fixed 5-row by 3-column matrix for the key map function.
package kms_pkg;
    localparam int BTN_W = 12;

    localparam int BIT_LEFT   = 0;
    localparam int BIT_RIGHT  = 1;
    localparam int BIT_UP     = 2;
    localparam int BIT_DOWN   = 3;
    localparam int BIT_SELECT = 4;
    localparam int BIT_BACK   = 5;
    localparam int BIT_MENU   = 6;
    localparam int BIT_VOLUP  = 7;
    localparam int BIT_VOLDN  = 8;
    localparam int BIT_PREV   = 9;
    localparam int BIT_PLAY   = 10;
    localparam int BIT_NEXT   = 11;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PRECH = 2'd1,
        ST_STROBE = 2'd2
    } scan_state_t;

    // Button mask for the key at (row r, column c); zero for empty positions.
    function automatic logic [BTN_W-1:0] key_mask(input int r, input int c);
        int idx;
        idx = -1;
        case (r * 3 + c)
            0:  idx = BIT_LEFT;
            1:  idx = BIT_BACK;
            2:  idx = BIT_VOLUP;
            3:  idx = BIT_UP;
            4:  idx = BIT_MENU;
            5:  idx = BIT_VOLDN;
            6:  idx = BIT_DOWN;
            8:  idx = BIT_PREV;
            9:  idx = BIT_RIGHT;
            11: idx = BIT_PLAY;
            12: idx = BIT_SELECT;
            14: idx = BIT_NEXT;
            default: idx = -1;
        endcase
        if (idx < 0) return '0;
        return BTN_W'(1) << idx;
    endfunction
endpackage

// File: rtl/kms_row_sync.sv
// Multi-flop synchronizer for the asynchronous row lines.
// Assumes rows idle high; resets to all ones (no key seen).
module kms_row_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Each stage re-registers the previous one.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= '1;
                else        chain[s] <= (s == 0) ? d_i : chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/kms_settle_timer.sv
// Down-counter giving a wait of exactly LEN cycles from a start pulse.
// Assumes LEN >= 2; done is high on the last cycle of the window.
module kms_settle_timer #(
    parameter int LEN = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic done_o
);
    localparam int CW = $clog2(LEN + 1);
    logic [CW-1:0] cnt;

    // Load on start, then count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (start_i)    cnt <= CW'(LEN - 1);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign done_o = (cnt == '0);
endmodule

// File: rtl/kms_key_decode.sv
// Maps the sampled active-low rows of one strobed column to button bits.
// Assumes rows are already synchronized; purely combinational.
module kms_key_decode #(
    parameter int ROWS = 5,
    parameter int COLS = 3,
    localparam int CIW = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic [CIW-1:0]             col_sel_i,
    input  logic [ROWS-1:0]            rows_n_i,
    output logic [kms_pkg::BTN_W-1:0]  mask_o
);
    // OR the map entry of every low row on the selected column.
    always_comb begin
        mask_o = '0;
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                if (col_sel_i == CIW'(c) && !rows_n_i[r])
                    mask_o = mask_o | kms_pkg::key_mask(r, c);
            end
        end
    end
endmodule

// File: rtl/keymatrix_scanner.sv
// Event-triggered keypad matrix scanner (5 rows x 3 columns).
// Idles with columns low, scans on an armed press or release event with a
// push-pull precharge and open-drain strobe per column, then latches the
// button word and re-arms one detection mode. Assumes SETTLE covers the
// synchronizer latency.
module keymatrix_scanner #(
    parameter int ROWS        = 5,
    parameter int COLS        = 3,
    parameter int SETTLE      = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ROWS-1:0]            row_n_i,
    input  logic                       hold_i,
    output logic [COLS-1:0]            col_o,
    output logic                       col_pp_o,
    output logic                       arm_press_o,
    output logic                       arm_release_o,
    output logic [kms_pkg::BTN_W-1:0]  btn_o,
    output logic                       btn_valid_o
);
    import kms_pkg::*;

    localparam int CIW   = (COLS > 1) ? $clog2(COLS) : 1;
    localparam int GUARD = SYNC_STAGES + 1;
    localparam int GW    = $clog2(GUARD + 1);

    scan_state_t      state;
    logic [CIW-1:0]   col_idx;
    logic [BTN_W-1:0] acc, word, col_mask, acc_next;
    logic             arm_p, arm_r, valid_q;
    logic [GW-1:0]    guard;
    logic [ROWS-1:0]  rows_s;
    logic             t_done, t_start, fire, last_col;

    kms_row_sync #(.WIDTH(ROWS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(row_n_i), .q_o(rows_s)
    );

    kms_settle_timer #(.LEN(SETTLE)) u_timer (
        .clk(clk), .rst_n(rst_n), .start_i(t_start), .done_o(t_done)
    );

    kms_key_decode #(.ROWS(ROWS), .COLS(COLS)) u_dec (
        .col_sel_i(col_idx), .rows_n_i(rows_s), .mask_o(col_mask)
    );

    // Event detection and timer start conditions.
    always_comb begin
        fire     = (state == ST_IDLE) && (guard == '0) &&
                   ((arm_p && !(&rows_s)) || (arm_r && (&rows_s)));
        last_col = (col_idx == CIW'(COLS - 1));
        acc_next = acc | col_mask;
        t_start  = fire || (state == ST_PRECH && t_done) ||
                   (state == ST_STROBE && t_done && !last_col);
    end

    // Scan sequencer: idle watch, precharge, strobe/sample, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            col_idx <= '0;
            acc     <= '0;
            word    <= '0;
            arm_p   <= 1'b1;
            arm_r   <= 1'b1;
            valid_q <= 1'b0;
            guard   <= GW'(GUARD);
        end else begin
            valid_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (guard != '0) guard <= guard - 1'b1;
                    else if (fire) begin
                        arm_p   <= 1'b0;
                        arm_r   <= 1'b0;
                        col_idx <= '0;
                        acc     <= '0;
                        state   <= ST_PRECH;
                    end
                end
                ST_PRECH: if (t_done) state <= ST_STROBE;
                ST_STROBE: if (t_done) begin
                    acc <= acc_next;
                    if (last_col) begin
                        word    <= acc_next;
                        arm_r   <= (word != '0);
                        arm_p   <= (word == '0);
                        valid_q <= 1'b1;
                        guard   <= GW'(GUARD);
                        state   <= ST_IDLE;
                    end else begin
                        col_idx <= col_idx + 1'b1;
                        state   <= ST_PRECH;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Column drive: all high in precharge, one low in strobe, all low idle.
    always_comb begin
        case (state)
            ST_PRECH:  col_o = '1;
            ST_STROBE: col_o = ~(COLS'(1) << col_idx);
            default:   col_o = '0;
        endcase
        col_pp_o = (state == ST_PRECH);
    end

    assign arm_press_o   = arm_p;
    assign arm_release_o = arm_r;
    assign btn_valid_o   = valid_q;
    assign btn_o         = hold_i ? '0 : word;
endmodule

// File: rtl/kms_checker.sv
// Property checker for keymatrix_scanner, observing its ports only.
// Assumes the default single-column strobe scheme.
module kms_checker #(
    parameter int COLS   = 3,
    parameter int SETTLE = 256
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      hold_i,
    input logic [COLS-1:0]           col_o,
    input logic                      col_pp_o,
    input logic                      arm_press_o,
    input logic                      arm_release_o,
    input logic [kms_pkg::BTN_W-1:0] btn_o,
    input logic                      btn_valid_o
);
    localparam int PW = $clog2(SETTLE + 2);
    logic [PW-1:0] pre_cnt;

    // Counts consecutive precharge cycles seen so far.
    always_ff @(posedge clk) begin
        if (!rst_n)        pre_cnt <= '0;
        else if (col_pp_o) pre_cnt <= pre_cnt + 1'b1;
        else               pre_cnt <= '0;
    end

    p_armed_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_press_o || arm_release_o) |-> (col_o == '0 && !col_pp_o));
    p_prech_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        col_pp_o |-> (&col_o));
    p_prech_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        col_pp_o |-> (pre_cnt < PW'(SETTLE)));
    p_strobe_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!col_pp_o && col_o != '0) |-> ($countones(~col_o) == 1));
    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        btn_valid_o |=> !btn_valid_o);
    p_valid_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        btn_valid_o |-> (col_o == '0 && !col_pp_o));
    p_one_arm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        btn_valid_o |-> ($countones({arm_press_o, arm_release_o}) == 1));
    p_hold_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |-> (btn_o == '0));
endmodule

bind keymatrix_scanner kms_checker #(.COLS(COLS), .SETTLE(SETTLE)) u_chk (
    .clk(clk), .rst_n(rst_n), .hold_i(hold_i), .col_o(col_o),
    .col_pp_o(col_pp_o), .arm_press_o(arm_press_o),
    .arm_release_o(arm_release_o), .btn_o(btn_o), .btn_valid_o(btn_valid_o)
);

// File: tb/keymatrix_scanner_tb.sv
`timescale 1ns/1ps
module keymatrix_scanner_tb;
    localparam int SETTLE = 256;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [4:0]  row_n;
    logic        hold = 0;
    logic [2:0]  col;
    logic        col_pp, arm_p, arm_r, valid;
    logic [11:0] btn;
    logic [14:0] keys = '0;   // bit r*3+c = key at row r, column c pressed
    int checks = 0, bad = 0, cyc = 0;
    bit done_flag = 0;
    logic [11:0] prev_word = '0;

    // Expected bit per matrix position (-1 = none), from R5.
    int bit_of [15] = '{0, 5, 7, 2, 6, 8, 3, -1, 9, 1, -1, 10, 4, -1, 11};

    always #2.5 clk = ~clk;

    keymatrix_scanner u_dut (
        .clk(clk), .rst_n(rst_n), .row_n_i(row_n), .hold_i(hold),
        .col_o(col), .col_pp_o(col_pp), .arm_press_o(arm_p),
        .arm_release_o(arm_r), .btn_o(btn), .btn_valid_o(valid)
    );

    // Physical matrix model: a row is low if a pressed key sits on a low column.
    always_comb begin
        for (int r = 0; r < 5; r++) begin
            row_n[r] = 1'b1;
            for (int c = 0; c < 3; c++)
                if (keys[r*3+c] && !col[c]) row_n[r] = 1'b0;
        end
    end

    function automatic logic [11:0] expect_word(input logic [14:0] k);
        logic [11:0] w = '0;
        for (int p = 0; p < 15; p++)
            if (k[p] && bit_of[p] >= 0) w[bit_of[p]] = 1'b1;
        return w;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 195000) begin
            bad++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 195000);
            finish_run();
        end
    end

    task automatic wait_valid(input string req);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!valid && n < 5000);
        chk(valid, {req, " valid timeout"}, n, 0);
    endtask

    task automatic wait_quiet();
        int q = 0;
        while (q < 1800) begin
            @(negedge clk);
            q = valid ? 0 : q + 1;
        end
    endtask

    // Check word and arm state after a scan result; update model of latched word.
    task automatic check_result(input logic [11:0] exp, input string tag);
        chk(btn == exp, {"R5 word ", tag}, btn, exp);
        chk(arm_r == (prev_word != 0) && arm_p == (prev_word == 0),
            {"R7 arm ", tag}, {arm_p, arm_r}, {prev_word == 0, prev_word != 0});
        prev_word = exp;
    endtask

    // Measure precharge and strobe windows of a scan in progress (R3, R4).
    task automatic measure_scan();
        int n = 0;
        while (!col_pp && n < 5000) begin @(negedge clk); n++; end
        for (int c = 0; c < 3; c++) begin
            int pre = 0, stb = 0;
            logic [2:0] exp_col = ~(3'b001 << c);
            while (col_pp && col == 3'b111 && pre < 600) begin @(negedge clk); pre++; end
            chk(pre == SETTLE, "R3 precharge length", pre, SETTLE);
            while (!col_pp && col == exp_col && stb < 600) begin @(negedge clk); stb++; end
            chk(stb == SETTLE, "R4 strobe length/order", stb, SETTLE);
        end
        chk(col == 3'b000 && !col_pp, "R6 columns low at end", col, 0);
        chk(valid == 1'b1, "R6 valid at end of scan", valid, 1);
    endtask

    task automatic run_pattern(input logic [14:0] k, input string tag, input bit measure,
                               input bit do_hold);
        logic [11:0] w = expect_word(k);
        keys = k;
        if (measure) measure_scan();
        else wait_valid("R2 press");
        check_result(w, {tag, " scan1"});
        if (w != 0) begin
            wait_valid("R2 rescan");
            check_result(w, {tag, " scan2"});
            @(negedge clk);
            chk(valid == 1'b0, "R6 one-cycle valid", valid, 0);
            if (do_hold) begin
                hold = 1;
                #1;
                chk(btn == 0, "R9 hold masks", btn, 0);
                repeat (50) @(negedge clk);
                chk(btn == 0, "R9 hold masks later", btn, 0);
                hold = 0;
                #1;
                chk(btn == w, "R9 word back after hold", btn, w);
            end
            keys = '0;
            wait_valid("R2 release");
            check_result(12'h000, {tag, " release1"});
            wait_valid("R2 release2");
            check_result(12'h000, {tag, " release2"});
        end else begin
            keys = '0;
            wait_quiet();
            chk(btn == 0 && arm_p && !arm_r, {"R7 none-key settles ", tag}, {arm_p, arm_r}, 2);
            prev_word = 0;
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk(btn == 0 && arm_p && arm_r && !valid && col == 0, "R8 reset state",
            {btn, arm_p, arm_r}, 3);
        rst_n = 1;
        wait_valid("R8 first scan");
        check_result(12'h000, "R8 first scan");
        wait_quiet();
        chk(col == 0 && !col_pp && arm_p && !arm_r, "R1 idle columns low", {col, col_pp}, 0);
        repeat (100) @(negedge clk);
        chk(btn == 0 && col == 0, "R1 no scan without event", btn, 0);

        run_pattern(15'b1, "pos0", 1'b1, 1'b0);
        for (int p = 1; p < 15; p++)
            run_pattern(15'(1) << p, $sformatf("pos%0d", p), 1'b0, 1'b0);
        // Column 0 keys, row 0 keys, spread set, all keys (R5 OR).
        run_pattern(15'b001_001_001_001_001, "col0 all", 1'b0, 1'b0);
        run_pattern(15'b000_000_000_000_111, "row0 all", 1'b0, 1'b0);
        run_pattern(15'b100_000_000_010_001, "spread", 1'b0, 1'b1);
        run_pattern(15'h7FFF, "all keys", 1'b0, 1'b0);
        finish_run();
    end
endmodule